// File: doc/BRIEF.md
# Coarse Oscillator Code Calibrator

This block picks the coarse tuning code of an oscillator while a link is still in its training phase, before any phase tracking begins. During training the incoming data is a steady one-zero toggle pattern. A divided copy of that pattern therefore serves as a frequency reference. The block compares it against a divided copy of the oscillator output and adjusts an 8-bit code. A larger code gives a faster oscillator.

Each comparison is a race between two counters. One counter counts rising edges of the reference and the other counts rising edges of the oscillator. The trial ends as soon as either counter fills. The two counts are then compared, which yields a Fast or Slow verdict.

The verdicts drive a successive-approximation search over the code. The search tries the most significant bit first and settles one bit per trial. After the last bit it raises `done` and holds the code until software pulses `start` again. Both divided inputs are asynchronous to the system clock and are brought into its domain inside the block.

Top module: `vco_code_cal`

## Requirements
- R1: After reset, `code` is 0 and `fast`, `slow` and `done` are all low.
- R2: A `start` pulse seen while idle or finished begins a new search. On the next clock `done` is low, both verdict flags are low and `code` is 8'h80 (only the top bit set as the first trial).
- R3: Each trial first clears both counters. Each counter then counts rising edges of its synchronized input, discarding the first edge after the clear. The trial ends once either counter holds 2^8-1. So a trial lasts about 256 periods of the faster input.
- R4: At the end of a trial, `fast` is set when the oscillator count exceeds the reference count, and `slow` is set when it is below. Both are low on a tie. The two flags are never high together, and they hold until the next verdict.
- R5: A Fast verdict clears the bit under trial. A Slow verdict or a tie keeps it. The next lower bit is then set for the next trial. For an oscillator whose frequency rises monotonically with the code, the final code lies within one LSB of the code that matches the reference.
- R6: After the eighth trial, `done` goes high. While `start` stays low, `done`, `code`, `fast` and `slow` keep their values.
- R7: A `start` pulse during a search is ignored. The search continues, and the trial code does not change while a trial is counting.
- R8: If the oscillator is faster than the reference at every code, the result is 8'h00 with the last verdict Fast. If it is slower at every code, the result is 8'hFF with the last verdict Slow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a calibration search |
| ref_div | input | 1 | Divided training pattern (reference), asynchronous |
| osc_div | input | 1 | Divided oscillator clock, asynchronous |
| code | output | 8 | Coarse oscillator code (trial value during search, result when done) |
| fast | output | 1 | Last verdict: oscillator faster than reference |
| slow | output | 1 | Last verdict: oscillator slower than reference |
| done | output | 1 | Search finished; code is final |

## Verification
The hardest condition to create from the ports is a closed loop in which the design's own code output changes the frequency it then measures. Without that loop, the search path and its final accuracy cannot be observed. The bench closes the loop with a behavioural oscillator whose period is recomputed from `code` on every half cycle, with frequency rising linearly with the code. The reference is a free-running clock that the bench sets per test, so the ideal code is known exactly. Extreme references push the search to both rails. A start pulse timed to land in the middle of a known trial sequence, together with a measurement of the first trial's length in clocks, shows that restarts are ignored and that trials end on counter fill.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ARM    = 3'd1,
    S_RUN    = 3'd2,
    S_DECIDE = 3'd3,
    S_DONE   = 3'd4
  } cal_state_e;

  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_OSC = 1;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/vcal_edge_sync.sv
module vcal_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vcal_race_cnt.sv
module vcal_race_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             rise,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (en && rise) begin
      if (!seen_q)               seen_q <= 1'b1;
      else if (cnt_q != CNT_MAX) cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == CNT_MAX);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full); // R3
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/vcal_sar_fsm.sv
module vcal_sar_fsm #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic [CNT_W-1:0]  osc_cnt,
  input  logic              ref_full,
  input  logic              osc_full,
  output logic              cnt_clr,
  output logic              cnt_en,
  output logic [CODE_W-1:0] code,
  output logic              fast,
  output logic              slow,
  output logic              done
);
  import vcal_pkg::*;

  localparam int unsigned      IDX_W    = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CODE_W-1:0] ONE     = {{(CODE_W-1){1'b0}}, 1'b1};
  localparam logic [CODE_W-1:0] MSB_CODE = ONE << (CODE_W-1);
  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(CODE_W-1);

  cal_state_e        st_q;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx_q;
  logic              fast_q, slow_q, done_q;

  logic              osc_gt, osc_lt;
  logic [CODE_W-1:0] kept_code;

  always_comb begin
    osc_gt    = (osc_cnt > ref_cnt);
    osc_lt    = (osc_cnt < ref_cnt);
    kept_code = osc_gt ? (code_q & ~(ONE << idx_q)) : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= '0;
      idx_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE: begin
          if (start) begin
            code_q <= MSB_CODE;
            idx_q  <= TOP_IDX;
            fast_q <= 1'b0;
            slow_q <= 1'b0;
            done_q <= 1'b0;
            st_q   <= S_ARM;
          end
        end
        S_ARM: st_q <= S_RUN;
        S_RUN: if (ref_full || osc_full) st_q <= S_DECIDE;
        S_DECIDE: begin
          fast_q <= osc_gt;
          slow_q <= osc_lt;
          if (idx_q == '0) begin
            code_q <= kept_code;
            done_q <= 1'b1;
            st_q   <= S_DONE;
          end else begin
            code_q <= kept_code | (ONE << (idx_q - 1'b1));
            idx_q  <= idx_q - 1'b1;
            st_q   <= S_ARM;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cnt_clr = (st_q == S_ARM);
  assign cnt_en  = (st_q == S_RUN);
  assign code    = code_q;
  assign fast    = fast_q;
  assign slow    = slow_q;
  assign done    = done_q;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fast_q, slow_q})); // R4
  AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st_q == S_IDLE || st_q == S_DONE)) |=> (code_q == MSB_CODE && !done_q)); // R2
  AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN) |=> $stable(code_q)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> (done_q && $stable(code_q) && $stable(fast_q) && $stable(slow_q))); // R6
endmodule

// File: rtl/vco_code_cal.sv
module vco_code_cal #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ref_div,
  input  logic              osc_div,
  output logic [CODE_W-1:0] code,
  output logic              fast,
  output logic              slow,
  output logic              done
);
  import vcal_pkg::*;

  logic [NUM_CH-1:0]            raw_in;
  logic [NUM_CH-1:0]            rise;
  logic [NUM_CH-1:0]            full;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt;
  logic                         cnt_clr, cnt_en;

  assign raw_in[CH_REF] = ref_div;
  assign raw_in[CH_OSC] = osc_div;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    vcal_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in[ch]),
      .rise     (rise[ch])
    );
    vcal_race_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (cnt_en),
      .rise  (rise[ch]),
      .cnt   (cnt[ch]),
      .full  (full[ch])
    );
  end

  vcal_sar_fsm #(.CODE_W(CODE_W), .CNT_W(CNT_W)) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ref_cnt  (cnt[CH_REF]),
    .osc_cnt  (cnt[CH_OSC]),
    .ref_full (full[CH_REF]),
    .osc_full (full[CH_OSC]),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .code     (code),
    .fast     (fast),
    .slow     (slow),
    .done     (done)
  );
endmodule

// File: tb/vco_code_cal_tb_top.sv
`timescale 1ns/1ps
module vco_code_cal_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       ref_div = 1'b0;
  logic       osc_div = 1'b0;
  logic [7:0] code;
  logic       fast, slow, done;

  int unsigned total = 0;
  int unsigned bad = 0;
  int unsigned cycles = 0;
  int          ref_f10 = 160;   // reference frequency in units of 0.1 MHz

  // ref tenths of MHz, expected code, expected last verdict (0 none-check, 1 fast, 2 slow)
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{120,  20, 0},
    '{160,  40, 0},
    '{200,  60, 0},
    '{240,  80, 0},
    '{ 60,   0, 1},
    '{600, 255, 2}
  };

  vco_code_cal dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_div(ref_div),
    .osc_div(osc_div), .code(code), .fast(fast), .slow(slow), .done(done)
  );

  always #4 clk = ~clk;

  // Oscillator model: f = 8 MHz + 0.2 MHz per code step
  always begin
    automatic real half = 500.0 / (8.0 + 0.2 * real'(code));
    #(half) osc_div = ~osc_div;
  end

  always begin
    automatic real half = 5000.0 / real'(ref_f10);
    #(half) ref_div = ~ref_div;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    bit ok;
    int diff;
    logic [7:0] held;
    int dur;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(code == 8'h00 && !fast && !slow && !done, "R1 reset outputs", {fast, slow, done, code}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      ref_f10 = VEC[v][0];
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      // R2: first trial code and done low one clock after start
      chk(code == 8'h80 && !done && !fast && !slow, "R2 first trial", code, 128);
      wait_done(ok);
      chk(ok, "R6 done reached", ok, 1);
      diff = int'(code) - VEC[v][1];
      // R5 / R8: result accuracy
      chk(diff <= 1 && diff >= -1, "R5 R8 final code", code, VEC[v][1]);
      chk(!(fast && slow), "R4 flags exclusive", {fast, slow}, 0);
      if (VEC[v][2] == 1) chk(fast && !slow, "R4 R8 last verdict fast", {fast, slow}, 2);
      if (VEC[v][2] == 2) chk(slow && !fast, "R4 R8 last verdict slow", {fast, slow}, 1);
      held = code;
      repeat (40) @(negedge clk);
      chk(done && code == held, "R6 result held", code, held);
    end

    // R3: first trial length; ref 16 MHz, osc at code 128 is 33.6 MHz,
    // trial ends after 256 osc rising edges (~952 clocks)
    ref_f10 = 160;
    pulse_start();
    dur = 1;
    while (code == 8'h80 && dur < 5000) begin
      @(negedge clk);
      dur++;
    end
    chk(dur >= 925 && dur <= 985, "R3 trial length in clocks", dur, 952);

    // R7: start mid-search is ignored (search path 128,64,32,...)
    while (code != 8'h20 && !done) @(negedge clk);
    pulse_start();
    chk(code != 8'h80 && !done, "R7 start ignored mid-search", code, 32);
    wait_done(ok);
    diff = int'(code) - 40;
    chk(ok && diff <= 1 && diff >= -1, "R7 search completes after ignored start", code, 40);

    // R2: restart from done drops done immediately
    ref_f10 = 200;
    pulse_start();
    chk(!done && code == 8'h80, "R2 restart from done", done, 0);
    wait_done(ok);
    diff = int'(code) - 60;
    chk(ok && diff <= 1 && diff >= -1, "R5 rerun result", code, 60);

    finish_run();
  end
endmodule